// File: doc/BRIEF.md
# 8-bit ALU with per-flag write enables

This block is the combinational arithmetic and logic unit of an 8-bit accumulator processor. Each cycle it takes an operation code, a first operand `a` (the accumulator, an index register or a memory byte), a second operand `b`, and the current carry, overflow and decimal flags. From these it produces a result byte, new values for the negative, zero, carry and overflow flags, a write-enable for each of those four flags, and a result write-enable.

Each operation touches only its own set of flags. When a flag's write-enable is low, that flag's output is the incoming value unchanged. The surrounding datapath can therefore write the flag outputs straight back without masking them. Compare and bit-test report flags but keep their result off the register file.

Decimal arithmetic is not implemented. The decimal flag input is accepted but has no effect, and arithmetic is always binary.

Top module: `alu8_flags`

## Requirements
- R1: Operation codes: 0 OR, 1 AND, 2 XOR, 3 add, 4 compare, 5 subtract, 6 bit test, 7 shift left, 8 logical shift right, 9 rotate left, 10 rotate right, 11 increment, 12 decrement. OR, AND and XOR produce `a|b`, `a&b` and `a^b`. They set `flag_we` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V) to 4'b1100.
- R2: Add produces `a+b+c_in`. C is the carry out of bit 7. V is set when `a` and `b` share a sign and the result sign differs from it. `flag_we` is 4'b1111.
- R3: Subtract produces `a+~b+c_in`, so C=1 means no borrow. V is set when the signs of `a` and `b` differ and the result sign differs from the sign of `a`. `flag_we` is 4'b1111.
- R4: Compare outputs `a-b` as the result with carry-in forced to 1. C is set when `a >= b` (unsigned). N and Z follow the difference. V is not touched, `flag_we` is 4'b1110 and `res_we` is 0.
- R5: Bit test sets N from `b[7]`, V from `b[6]`, and Z when `a&b` is zero. C is not touched, `flag_we` is 4'b1101 and `res_we` is 0.
- R6: Shift left moves 0 into bit 0 and bit 7 into C. Logical shift right moves 0 into bit 7 and bit 0 into C, so N is always 0. Both use `flag_we` 4'b1110.
- R7: Rotate left and rotate right move `c_in` into the vacated bit and the bit shifted out into C. `flag_we` is 4'b1110.
- R8: Increment and decrement produce `a+1` and `a-1` modulo 256. `flag_we` is 4'b1100.
- R9: Except for the bit test, N is bit 7 of the result and Z is set when the result is zero. A flag whose write-enable is low is output equal to its input (`c_out=c_in`, `v_out=v_in`). `res_we` is 1 for codes 0-3, 5 and 7-12.
- R10: `d_in` has no effect on any output. Add and subtract stay binary when it is 1.
- R11: Codes 13 to 15 output `a` as the result, with `res_we` 0 and `flag_we` 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| a | input | 8 | First operand (register or memory byte) |
| b | input | 8 | Second operand |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| d_in | input | 1 | Current decimal flag (ignored) |
| result | output | 8 | Result byte |
| res_we | output | 1 | Result should be written back |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| c_out | output | 1 | Carry flag |
| v_out | output | 1 | Overflow flag |
| flag_we | output | 4 | Flag write-enables: N, Z, C, V from bit 3 down |

## Verification
The assertions check, whenever the inputs change, that untouched C and V pass through, and that add agrees with a wide sum. They also check that compare's carry matches an unsigned comparison, that bit test copies the operand's top two bits, that logical shift right never reports a negative result, and that unused codes write nothing. Other behaviours can only be shown by the bench scenarios against its reference model: the exact flag masks, the rotate fill bits, wrap-around at 0x00 and 0xFF, signed overflow on subtract, and the decimal flag having no effect. These are run with directed corner operands and with random operands across all carry-in and overflow-in values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;

  typedef enum logic [3:0] {
    OP_OR  = 4'd0,
    OP_AND = 4'd1,
    OP_XOR = 4'd2,
    OP_ADC = 4'd3,
    OP_CMP = 4'd4,
    OP_SBC = 4'd5,
    OP_BIT = 4'd6,
    OP_ASL = 4'd7,
    OP_LSR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12
  } alu_op_e;

  localparam logic [3:0] MASK_NZ   = 4'b1100;
  localparam logic [3:0] MASK_NZC  = 4'b1110;
  localparam logic [3:0] MASK_NZV  = 4'b1101;
  localparam logic [3:0] MASK_ALL  = 4'b1111;
  localparam logic [3:0] MASK_NONE = 4'b0000;
endpackage

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    case (sel)
      2'd0:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = a & b;
    endcase
  end
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             inv,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  always_comb begin
    b_eff = inv ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
    sum   = full[WIDTH-1:0];
    cout  = full[WIDTH];
    ovf   = (a[MSB] == b_eff[MSB]) && (full[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic             cin,
  input  logic             right,
  input  logic             rotate,
  output logic [WIDTH-1:0] y,
  output logic             cout
);
  localparam int unsigned MSB = WIDTH - 1;

  logic fill;

  always_comb begin
    fill = rotate & cin;
    if (right) begin
      y    = {fill, a[MSB:1]};
      cout = a[0];
    end else begin
      y    = {a[MSB-1:0], fill};
      cout = a[MSB];
    end
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             c_in,
  input  logic             v_in,
  input  logic             d_in,
  output logic [WIDTH-1:0] result,
  output logic             res_we,
  output logic             n_out,
  output logic             z_out,
  output logic             c_out,
  output logic             v_out,
  output logic [3:0]       flag_we
);
  import alu8_pkg::*;

  localparam int unsigned MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  alu_op_e          op_e;
  logic [1:0]       logic_sel;
  logic [WIDTH-1:0] logic_y;
  logic             as_inv;
  logic             as_cin;
  logic [WIDTH-1:0] as_sum;
  logic             as_cout;
  logic             as_ovf;
  logic             sh_right;
  logic             sh_rot;
  logic [WIDTH-1:0] sh_y;
  logic             sh_cout;
  logic             unused_dec;

  assign unused_dec = d_in;
  assign op_e       = alu_op_e'(op);

  always_comb begin
    case (op_e)
      OP_OR:   logic_sel = 2'd0;
      OP_XOR:  logic_sel = 2'd2;
      default: logic_sel = 2'd1;
    endcase
    as_inv   = (op_e == OP_SBC) || (op_e == OP_CMP);
    as_cin   = (op_e == OP_CMP) ? 1'b1 : c_in;
    sh_right = (op_e == OP_LSR) || (op_e == OP_ROR);
    sh_rot   = (op_e == OP_ROL) || (op_e == OP_ROR);
  end

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .a(a), .b(b), .sel(logic_sel), .y(logic_y)
  );

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(a), .b(b), .cin(as_cin), .inv(as_inv),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .a(a), .cin(c_in), .right(sh_right), .rotate(sh_rot),
    .y(sh_y), .cout(sh_cout)
  );

  logic [WIDTH-1:0] res_n;
  logic             c_new;
  logic             v_new;
  logic [3:0]       mask_n;
  logic             we_n;

  always_comb begin
    res_n  = a;
    c_new  = c_in;
    v_new  = v_in;
    mask_n = MASK_NZ;
    we_n   = 1'b1;
    case (op_e)
      OP_OR, OP_AND, OP_XOR: res_n = logic_y;
      OP_ADC, OP_SBC: begin
        res_n  = as_sum;
        c_new  = as_cout;
        v_new  = as_ovf;
        mask_n = MASK_ALL;
      end
      OP_CMP: begin
        res_n  = as_sum;
        c_new  = as_cout;
        mask_n = MASK_NZC;
        we_n   = 1'b0;
      end
      OP_BIT: begin
        res_n  = logic_y;
        v_new  = b[MSB-1];
        mask_n = MASK_NZV;
        we_n   = 1'b0;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res_n  = sh_y;
        c_new  = sh_cout;
        mask_n = MASK_NZC;
      end
      OP_INC: res_n = a + ONE;
      OP_DEC: res_n = a - ONE;
      default: begin
        mask_n = MASK_NONE;
        we_n   = 1'b0;
      end
    endcase
  end

  always_comb begin
    result  = res_n;
    res_we  = we_n;
    flag_we = mask_n;
    n_out   = (op_e == OP_BIT) ? b[MSB] : res_n[MSB];
    z_out   = (res_n == '0);
    c_out   = mask_n[FLAG_C] ? c_new : c_in;
    v_out   = mask_n[FLAG_V] ? v_new : v_in;
  end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [3:0]       op,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             c_in,
  input logic             v_in,
  input logic [WIDTH-1:0] result,
  input logic             res_we,
  input logic             n_out,
  input logic             c_out,
  input logic             v_out,
  input logic [3:0]       flag_we
);
  import alu8_pkg::*;

  logic [WIDTH:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, c_in};
    if (!$isunknown({op, a, b, c_in, v_in})) begin
      // R9
      c_hold_chk: assert (flag_we[FLAG_C] || (c_out == c_in));
      // R9
      v_hold_chk: assert (flag_we[FLAG_V] || (v_out == v_in));
      // R2
      adc_sum_chk: assert ((op != OP_ADC) || ({c_out, result} == wide_sum));
      // R4
      cmp_carry_chk: assert ((op != OP_CMP) || ((c_out == (a >= b)) && !res_we));
      // R5
      bit_flags_chk: assert ((op != OP_BIT) || ((n_out == b[WIDTH-1]) && (v_out == b[WIDTH-2])));
      // R6
      lsr_sign_chk: assert ((op != OP_LSR) || !n_out);
      // R11
      bad_op_chk: assert ((op <= OP_DEC) || ((flag_we == 4'b0000) && !res_we));
    end
  end
endmodule

bind alu8_flags alu8_flags_chk #(.WIDTH(WIDTH)) u_chk (
  .op(op), .a(a), .b(b), .c_in(c_in), .v_in(v_in),
  .result(result), .res_we(res_we), .n_out(n_out),
  .c_out(c_out), .v_out(v_out), .flag_we(flag_we)
);

// File: tb/alu8_flags_test.sv
`timescale 1ns/1ps
module alu8_flags_test;
  typedef struct {
    logic [7:0] res;
    logic       we;
    logic       n, z, c, v;
    logic [3:0] mask;
    string      tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] a, b;
  logic       c_in, v_in, d_in;
  logic [7:0] result;
  logic       res_we, n_out, z_out, c_out, v_out;
  logic [3:0] flag_we;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  exp_t sb_q[$];

  alu8_flags uut (
    .op(op), .a(a), .b(b), .c_in(c_in), .v_in(v_in), .d_in(d_in),
    .result(result), .res_we(res_we), .n_out(n_out), .z_out(z_out),
    .c_out(c_out), .v_out(v_out), .flag_we(flag_we)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic exp_t model(int code, logic [7:0] x, logic [7:0] y,
                                 logic ci, logic vi, string tag);
    exp_t e;
    logic [8:0] t;
    e.res = x; e.we = 1'b1; e.c = ci; e.v = vi; e.mask = 4'b1100; e.tag = tag;
    t = 9'd0;
    case (code)
      0: e.res = x | y;
      1: e.res = x & y;
      2: e.res = x ^ y;
      3: begin
        t = {1'b0, x} + {1'b0, y} + {8'd0, ci};
        e.res = t[7:0]; e.c = t[8];
        e.v = (x[7] == y[7]) && (t[7] != x[7]);
        e.mask = 4'b1111;
      end
      5: begin
        t = {1'b0, x} + {1'b0, ~y} + {8'd0, ci};
        e.res = t[7:0]; e.c = t[8];
        e.v = (x[7] != y[7]) && (t[7] != x[7]);
        e.mask = 4'b1111;
      end
      4: begin
        e.res = x - y; e.c = (x >= y); e.we = 1'b0; e.mask = 4'b1110;
      end
      6: begin
        e.res = x & y; e.v = y[6]; e.we = 1'b0; e.mask = 4'b1101;
      end
      7:  begin e.res = {x[6:0], 1'b0}; e.c = x[7]; e.mask = 4'b1110; end
      8:  begin e.res = {1'b0, x[7:1]}; e.c = x[0]; e.mask = 4'b1110; end
      9:  begin e.res = {x[6:0], ci};   e.c = x[7]; e.mask = 4'b1110; end
      10: begin e.res = {ci, x[7:1]};   e.c = x[0]; e.mask = 4'b1110; end
      11: e.res = x + 8'd1;
      12: e.res = x - 8'd1;
      default: begin e.we = 1'b0; e.mask = 4'b0000; end
    endcase
    if (code == 6) begin
      e.n = y[7]; e.z = ((x & y) == 8'd0);
    end else begin
      e.n = e.res[7]; e.z = (e.res == 8'd0);
    end
    return e;
  endfunction

  function automatic string tag_of(int code);
    case (code)
      0, 1, 2:  return "R1";
      3:        return "R2";
      4:        return "R4";
      5:        return "R3";
      6:        return "R5";
      7, 8:     return "R6";
      9, 10:    return "R7";
      11, 12:   return "R8";
      default:  return "R11";
    endcase
  endfunction

  task automatic apply(int code, logic [7:0] x, logic [7:0] y,
                       logic ci, logic vi, logic di, string tag);
    @(posedge clk);
    #1;
    op = 4'(code); a = x; b = y; c_in = ci; v_in = vi; d_in = di;
    sb_q.push_back(model(code, x, y, ci, vi, tag));
  endtask

  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (result !== e.res || res_we !== e.we || n_out !== e.n || z_out !== e.z ||
          c_out !== e.c || v_out !== e.v || flag_we !== e.mask) begin
        errors++;
        $display("FAIL %s op=%0d a=%h b=%h: got res=%h we=%b nzcv=%b%b%b%b mask=%b, exp res=%h we=%b nzcv=%b%b%b%b mask=%b",
                 e.tag, op, a, b, result, res_we, n_out, z_out, c_out, v_out, flag_we,
                 e.res, e.we, e.n, e.z, e.c, e.v, e.mask);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op = 4'd0; a = 8'd0; b = 8'd0; c_in = 1'b0; v_in = 1'b0; d_in = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R9: zero result, C and V pass through
    apply(0, 8'h00, 8'h00, 1, 1, 0, "R1");
    apply(1, 8'hF0, 8'h3C, 0, 1, 0, "R1");
    apply(2, 8'hFF, 8'h0F, 1, 0, 0, "R9");
    // R2: signed overflow, carry out with zero, both
    apply(3, 8'h7F, 8'h01, 0, 0, 0, "R2");
    apply(3, 8'hFF, 8'h01, 0, 1, 0, "R2");
    apply(3, 8'h80, 8'h80, 0, 0, 0, "R2");
    // R3: borrow, overflow, borrow-in
    apply(5, 8'h00, 8'h01, 1, 0, 0, "R3");
    apply(5, 8'h80, 8'h01, 1, 0, 0, "R3");
    apply(5, 8'h05, 8'h03, 0, 1, 0, "R3");
    // R4: equal, less, V held
    apply(4, 8'h10, 8'h10, 0, 1, 0, "R4");
    apply(4, 8'h0F, 8'h10, 1, 0, 0, "R4");
    // R5: bit test flags
    apply(6, 8'h0F, 8'hC0, 1, 0, 0, "R5");
    apply(6, 8'hFF, 8'h41, 0, 1, 0, "R5");
    // R6 / R7: shift and rotate edges
    apply(7, 8'h81, 8'h00, 0, 0, 0, "R6");
    apply(8, 8'h01, 8'h00, 0, 1, 0, "R6");
    apply(9, 8'h80, 8'h00, 1, 0, 0, "R7");
    apply(10, 8'h01, 8'h00, 1, 0, 0, "R7");
    apply(10, 8'h00, 8'h00, 0, 1, 0, "R7");
    // R8: wrap-around
    apply(11, 8'hFF, 8'h00, 1, 1, 0, "R8");
    apply(12, 8'h00, 8'h00, 0, 0, 0, "R8");
    // R10: decimal flag ignored
    apply(3, 8'h09, 8'h01, 0, 0, 1, "R10");
    apply(5, 8'h10, 8'h01, 1, 0, 1, "R10");
    // R11: unused codes
    apply(13, 8'h5A, 8'h00, 1, 0, 0, "R11");
    apply(15, 8'h00, 8'hFF, 0, 1, 0, "R11");

    for (int i = 0; i < 1200; i++) begin
      int code;
      code = int'($urandom_range(15, 0));
      apply(code, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), tag_of(code));
    end

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule